// File: doc/BRIEF.md
# H-Bridge Leg Control Logic

This block is the digital control core of a full-bridge motor driver. It takes two direction inputs, a speed PWM input and one enable line per half-bridge ("leg"). From these it produces four gate-enable signals: high side and low side for leg A and for leg B. The two direction inputs select one of four drive patterns: drive one way, drive the other way, brake to the supply, or brake to ground. The PWM input gates only the low-side switches.

Protection is part of the same logic. Digitised fault flags are handled per leg: high-side overtemperature and low-side saturation each latch only the affected leg off. That leg's diagnostic line is then pulled low through an open-drain pair made of an active-low level and an output enable. The latch releases only on a new low-to-high edge of that leg's direction input. Two supply flags, undervoltage and overvoltage, shut the whole bridge down while either is set. A change of drive pattern holds all four gates off for a programmable number of cycles, so that both switches of a leg never conduct at once.

The enable line of a leg is read from the resolved pin value. A fault that the block drives onto the pin is therefore also seen as a disable of that leg. Direction, PWM and enable inputs pass through a synchroniser before they are used. The fault and supply flags are treated as synchronous.

Top module: `hbridge_ctrl`

## Requirements
- R1: With PWM and both enables high, direction pair (dir_a, dir_b) selects the gates as follows: 11 turns on gate_hsa and gate_hsb; 10 turns on gate_hsa and gate_lsb; 01 turns on gate_lsa and gate_hsb; 00 turns on gate_lsa and gate_lsb. All other gates are off.
- R2: While the synchronised PWM input is 0, both low-side gates are off and the high-side gates are unaffected. When PWM returns to 1, the low-side gates follow the current direction inputs without any dead gap.
- R3: A low enable pin switches off both gates of its leg. The other leg is unaffected.
- R4: A fault flag on a leg (hs_ot_x or ls_sat_x) sampled on a clock edge turns off both gates of that leg from that edge on. From the same edge, diag_x_oe is 1 and diag_x_n is 0. The other leg is unaffected.
- R5: A latched leg stays off, with its diagnostic asserted, after the flag clears and after a falling direction edge. It releases only on a rising edge of its synchronised direction input that occurs while no fault flag is present on that leg.
- R6: While uv_flag or ov_flag is 1 at a clock edge, all four gates are off after that edge. They return at the first edge with both flags clear.
- R7: When the synchronised direction pair changes (three edges after the input change), all four gates are off for exactly DEAD_CYC cycles. After that the new pattern appears.
- R8: The high-side and low-side gates of one leg are never on in the same cycle.
- R9: Synchronous active-high reset turns off all gates, releases both diagnostics and clears both fault latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_a | input | 1 | Direction input of leg A |
| dir_b | input | 1 | Direction input of leg B |
| pwm_in | input | 1 | Speed PWM, gates the low sides |
| en_a_pin | input | 1 | Resolved level of the leg A enable/diagnostic pin |
| en_b_pin | input | 1 | Resolved level of the leg B enable/diagnostic pin |
| hs_ot_a | input | 1 | High-side overtemperature flag, leg A |
| ls_sat_a | input | 1 | Low-side saturation flag, leg A |
| hs_ot_b | input | 1 | High-side overtemperature flag, leg B |
| ls_sat_b | input | 1 | Low-side saturation flag, leg B |
| uv_flag | input | 1 | Supply below operating window |
| ov_flag | input | 1 | Supply above operating window |
| gate_hsa | output | 1 | High-side gate enable, leg A |
| gate_lsa | output | 1 | Low-side gate enable, leg A |
| gate_hsb | output | 1 | High-side gate enable, leg B |
| gate_lsb | output | 1 | Low-side gate enable, leg B |
| diag_a_n | output | 1 | Active-low diagnostic level, leg A |
| diag_a_oe | output | 1 | Diagnostic drive enable, leg A |
| diag_b_n | output | 1 | Active-low diagnostic level, leg B |
| diag_b_oe | output | 1 | Diagnostic drive enable, leg B |

## Verification
The hardest situation to reach is a fault latch that must survive a rising direction edge. This happens when the fault flag is still present at the moment the synchronised edge arrives. The stimulus holds the saturation flag across a direction change and then clears it. It confirms the leg stays off, and only a second full low-high cycle of the direction input releases it. Release after reset without any rising edge is reached by latching leg B, resetting, and keeping dir_b low. The bench resolves each enable pin as the host level ANDed with the inverse of the block's own drive. This reproduces the self-disable loop through the pin.

// File: rtl/hbl_pkg.sv
`timescale 1ns/1ps
package hbl_pkg;
  typedef enum logic [1:0] {
    M_BRAKE_LO = 2'b00,
    M_CCW      = 2'b01,
    M_CW       = 2'b10,
    M_BRAKE_HI = 2'b11
  } drive_mode_t;

  localparam int NUM_LEGS = 2;

  // leg 0 (A) follows mode bit 1, leg 1 (B) follows mode bit 0
  function automatic logic leg_high(input drive_mode_t m, input int leg);
    return (leg == 0) ? m[1] : m[0];
  endfunction
endpackage

// File: rtl/hbl_sync.sv
`timescale 1ns/1ps
module hbl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbl_dead_gap.sv
`timescale 1ns/1ps
module hbl_dead_gap
  import hbl_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  drive_mode_t mode_in,
  output drive_mode_t mode_q,
  output logic        quiet
);
  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          change;

  assign change = (mode_in != mode_q);
  assign quiet  = change || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_BRAKE_LO;
      cnt_q  <= '0;
    end else if (change) begin
      mode_q <= mode_in;
      cnt_q  <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hbl_leg_latch.sv
`timescale 1ns/1ps
module hbl_leg_latch (
  input  logic clk,
  input  logic rst,
  input  logic dir_s,
  input  logic fault_in,
  output logic latched_q,
  output logic off_now
);
  logic dir_prev;
  logic rise;
  logic lat_nxt;

  assign rise    = dir_s & ~dir_prev;
  assign lat_nxt = fault_in | (latched_q & ~rise);
  assign off_now = lat_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_prev  <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      dir_prev  <= dir_s;
      latched_q <= lat_nxt;
    end
  end
endmodule

// File: rtl/hbridge_ctrl.sv
`timescale 1ns/1ps
module hbridge_ctrl
  import hbl_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dir_a,
  input  logic dir_b,
  input  logic pwm_in,
  input  logic en_a_pin,
  input  logic en_b_pin,
  input  logic hs_ot_a,
  input  logic ls_sat_a,
  input  logic hs_ot_b,
  input  logic ls_sat_b,
  input  logic uv_flag,
  input  logic ov_flag,
  output logic gate_hsa,
  output logic gate_lsa,
  output logic gate_hsb,
  output logic gate_lsb,
  output logic diag_a_n,
  output logic diag_a_oe,
  output logic diag_b_n,
  output logic diag_b_oe
);
  localparam int SW = 2 * NUM_LEGS + 1;

  logic [SW-1:0]       raw_in, syn;
  logic [NUM_LEGS-1:0] dir_s, en_s, fault_in, lat_q, off_now;
  logic [NUM_LEGS-1:0] hs_d, ls_d, hs_q, ls_q;
  logic                pwm_s, quiet, allow;
  drive_mode_t         mode_s, mode_q;

  assign raw_in = {en_b_pin, en_a_pin, pwm_in, dir_b, dir_a};

  hbl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign dir_s = syn[1:0];
  assign pwm_s = syn[2];
  assign en_s  = syn[4:3];

  assign mode_s = drive_mode_t'({dir_s[0], dir_s[1]});

  hbl_dead_gap #(.DEAD_CYC(DEAD_CYC)) u_gap (
    .clk(clk), .rst(rst), .mode_in(mode_s), .mode_q(mode_q), .quiet(quiet)
  );

  assign fault_in = {hs_ot_b | ls_sat_b, hs_ot_a | ls_sat_a};
  assign allow    = ~quiet & ~uv_flag & ~ov_flag;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic leg_ok;
    logic hi;

    hbl_leg_latch u_latch (
      .clk(clk), .rst(rst), .dir_s(dir_s[g]), .fault_in(fault_in[g]),
      .latched_q(lat_q[g]), .off_now(off_now[g])
    );

    assign leg_ok  = en_s[g] & ~off_now[g];
    assign hi      = leg_high(mode_q, g);
    assign hs_d[g] = allow & leg_ok & hi;
    assign ls_d[g] = allow & leg_ok & ~hi & pwm_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= '0;
      ls_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign gate_hsa  = hs_q[0];
  assign gate_lsa  = ls_q[0];
  assign gate_hsb  = hs_q[1];
  assign gate_lsb  = ls_q[1];
  assign diag_a_oe = lat_q[0];
  assign diag_a_n  = ~lat_q[0];
  assign diag_b_oe = lat_q[1];
  assign diag_b_n  = ~lat_q[1];
endmodule

// File: rtl/hbridge_ctrl_chk.sv
`timescale 1ns/1ps
module hbridge_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hs_ot_a,
  input logic ls_sat_a,
  input logic hs_ot_b,
  input logic ls_sat_b,
  input logic uv_flag,
  input logic ov_flag,
  input logic gate_hsa,
  input logic gate_lsa,
  input logic gate_hsb,
  input logic gate_lsb,
  input logic diag_a_oe,
  input logic diag_b_oe
);
  // R8
  no_shoot_a_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_hsa && gate_lsa));
  // R8
  no_shoot_b_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_hsb && gate_lsb));
  // R6
  supply_off_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_flag || ov_flag) |=> !(gate_hsa || gate_lsa || gate_hsb || gate_lsb));
  // R4
  fault_a_off_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_ot_a || ls_sat_a) |=> (!gate_hsa && !gate_lsa && diag_a_oe));
  // R4
  fault_b_off_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_ot_b || ls_sat_b) |=> (!gate_hsb && !gate_lsb && diag_b_oe));
  // R5
  latched_a_off_chk: assert property (@(posedge clk) disable iff (rst)
    diag_a_oe |-> (!gate_hsa && !gate_lsa));
  // R5
  latched_b_off_chk: assert property (@(posedge clk) disable iff (rst)
    diag_b_oe |-> (!gate_hsb && !gate_lsb));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !(gate_hsa || gate_lsa || gate_hsb || gate_lsb || diag_a_oe || diag_b_oe));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk(clk), .rst(rst),
  .hs_ot_a(hs_ot_a), .ls_sat_a(ls_sat_a), .hs_ot_b(hs_ot_b), .ls_sat_b(ls_sat_b),
  .uv_flag(uv_flag), .ov_flag(ov_flag),
  .gate_hsa(gate_hsa), .gate_lsa(gate_lsa), .gate_hsb(gate_hsb), .gate_lsb(gate_lsb),
  .diag_a_oe(diag_a_oe), .diag_b_oe(diag_b_oe)
);

// File: tb/hbridge_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_ctrl_bench;
  localparam int DEAD = 4;
  localparam int NV   = 11;
  // {dir_a, dir_b, pwm, host_en_a, host_en_b, exp {hsa,hsb,lsa,lsb}}
  localparam logic [8:0] VEC [NV] = '{
    9'b11111_1100, 9'b10111_1001, 9'b01111_0110, 9'b00111_0011,
    9'b10011_1000, 9'b00011_0000, 9'b01011_0100, 9'b10101_0001,
    9'b01110_0010, 9'b11100_0000, 9'b11111_1100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_a = 0, dir_b = 0, pwm_in = 1, host_a = 1, host_b = 1;
  logic hs_ot_a = 0, ls_sat_a = 0, hs_ot_b = 0, ls_sat_b = 0, uv_flag = 0, ov_flag = 0;
  logic gate_hsa, gate_lsa, gate_hsb, gate_lsb;
  logic diag_a_n, diag_a_oe, diag_b_n, diag_b_oe;
  logic en_a_pin, en_b_pin;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign en_a_pin = host_a & ~diag_a_oe;
  assign en_b_pin = host_b & ~diag_b_oe;

  hbridge_ctrl #(.DEAD_CYC(DEAD)) u_hbridge_ctrl (
    .clk(clk), .rst(rst), .dir_a(dir_a), .dir_b(dir_b), .pwm_in(pwm_in),
    .en_a_pin(en_a_pin), .en_b_pin(en_b_pin),
    .hs_ot_a(hs_ot_a), .ls_sat_a(ls_sat_a), .hs_ot_b(hs_ot_b), .ls_sat_b(ls_sat_b),
    .uv_flag(uv_flag), .ov_flag(ov_flag),
    .gate_hsa(gate_hsa), .gate_lsa(gate_lsa), .gate_hsb(gate_hsb), .gate_lsb(gate_lsb),
    .diag_a_n(diag_a_n), .diag_a_oe(diag_a_oe), .diag_b_n(diag_b_n), .diag_b_oe(diag_b_oe)
  );

  wire [3:0] g = {gate_hsa, gate_hsb, gate_lsa, gate_lsb};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk4(input string tag, input logic [3:0] exp);
    checks++;
    if (g !== exp) begin
      fails++;
      $display("FAIL %s: gates hsa,hsb,lsa,lsb got %b expected %b", tag, g, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(3);
    // R9 reset state
    chk4("R9 reset gates", 4'b0000);
    chk1("R9 reset diag_a_oe", diag_a_oe, 1'b0);
    chk1("R9 reset diag_b_n", diag_b_n, 1'b1);
    rst = 1'b0;
    tick(10);
    chk4("R1 brake low after reset", 4'b0011);

    // table walk: R1 / R2 / R3
    for (int i = 0; i < NV; i++) begin
      {dir_a, dir_b, pwm_in, host_a, host_b} = VEC[i][8:4];
      tick(12);
      if (!VEC[i][5] || !VEC[i][4]) chk4($sformatf("R3 vector %0d", i), VEC[i][3:0]);
      else if (!VEC[i][6])          chk4($sformatf("R2 vector %0d", i), VEC[i][3:0]);
      else                          chk4($sformatf("R1 vector %0d", i), VEC[i][3:0]);
    end

    // R7 dead gap: 11 -> 10
    dir_b = 1'b0;
    tick(2);
    chk4("R7 old pattern before sync", 4'b1100);
    tick(1);
    chk4("R7 gap start", 4'b0000);
    tick(DEAD - 1);
    chk4("R7 gap last cycle", 4'b0000);
    tick(1);
    chk4("R7 new pattern after gap", 4'b1001);

    // R2 pwm off/on, no gap
    pwm_in = 1'b0;
    tick(3);
    chk4("R2 pwm low", 4'b1000);
    pwm_in = 1'b1;
    tick(3);
    chk4("R2 pwm back no gap", 4'b1001);

    // R4 fault on leg A
    hs_ot_a = 1'b1;
    tick(1);
    chk4("R4 leg A off same edge", 4'b0001);
    chk1("R4 diag_a_oe", diag_a_oe, 1'b1);
    chk1("R4 diag_a_n", diag_a_n, 1'b0);
    chk1("R4 leg B diag untouched", diag_b_oe, 1'b0);
    hs_ot_a = 1'b0;
    tick(5);
    // R5 hold after flag clears
    chk4("R5 latched after flag clear", 4'b0001);
    dir_a = 1'b0;
    tick(12);
    chk4("R5 falling edge keeps latch", 4'b0001);
    chk1("R5 diag held on fall", diag_a_oe, 1'b1);
    dir_a = 1'b1;
    tick(12);
    chk4("R5 release on rising edge", 4'b1001);
    chk1("R5 diag released", diag_a_oe, 1'b0);

    // R5 flag present during rising edge keeps the latch
    ls_sat_b = 1'b1;
    tick(1);
    chk4("R4 leg B off", 4'b1000);
    dir_b = 1'b1;
    tick(12);
    chk4("R5 rise under flag no release", 4'b1000);
    ls_sat_b = 1'b0;
    tick(5);
    chk4("R5 still latched after flag gone", 4'b1000);
    chk1("R5 diag_b_oe held", diag_b_oe, 1'b1);
    dir_b = 1'b0;
    tick(12);
    dir_b = 1'b1;
    tick(12);
    chk4("R5 second rise releases", 4'b1100);

    // R6 supply window
    uv_flag = 1'b1;
    tick(1);
    chk4("R6 undervoltage off", 4'b0000);
    uv_flag = 1'b0;
    tick(1);
    chk4("R6 undervoltage recover", 4'b1100);
    ov_flag = 1'b1;
    tick(4);
    chk4("R6 overvoltage held off", 4'b0000);
    ov_flag = 1'b0;
    tick(1);
    chk4("R6 overvoltage recover", 4'b1100);

    // R9 reset clears latch without any rising edge on leg B
    dir_b = 1'b0;
    tick(12);
    ls_sat_b = 1'b1;
    tick(1);
    ls_sat_b = 1'b0;
    chk1("R4 leg B latched before reset", diag_b_oe, 1'b1);
    rst = 1'b1;
    tick(1);
    chk4("R9 reset mid-run gates", 4'b0000);
    chk1("R9 reset clears diag_b_oe", diag_b_oe, 1'b0);
    rst = 1'b0;
    tick(12);
    chk4("R9 leg B free after reset", 4'b1001);

    report();
    $finish;
  end
endmodule